// File: doc/BRIEF.md
# Serial Audio Subframe Field Checker

This block sits behind a line decoder in a digital audio receive path. The decoder has already recovered the bit clock and identified the preamble. It delivers each 32-slot subframe one slot at a time, on cycles where `slot_en` is high. With the first slot it also presents a 2-bit subframe kind. The checker collects the slots and splits them into the auxiliary nibble, the 20-bit audio word and the four trailing flag bits. It checks even parity over the payload slots. After the last slot it presents everything as one registered parallel word with a single-cycle strobe.

The block also keeps the position of the current frame inside a 192-frame status block. A block-start subframe resynchronises this position. If a block start arrives anywhere other than at the natural wrap point of an already locked count, the checker flags it. The parameter `AUX_AS_AUDIO` selects how the 24-bit sample output is laid out:
- With the parameter at 0, the nibble is reported only separately and the low four bits of the sample are zero.
- With the parameter at 1, the nibble forms the four low bits of a 24-bit sample.

Top module: `audio_subframe_checker`

## Requirements
- R1: Slot numbering restarts at 0 on the cycle where `slot_en` and `slot_sof` are both high. Slots 4..7 form `smp_aux` and slots 8..27 form the audio word. Both fields are sent least significant bit first, so slot 4 is `smp_aux[0]` and slot 8 is audio bit 0.
- R2: With `AUX_AS_AUDIO`=0, `smp_data` is {audio[19:0], 4'b0000}. With `AUX_AS_AUDIO`=1, `smp_data` is {audio[19:0], aux[3:0]}.
- R3: `parity_err` is 1 when the count of ones over slots 4..31 is odd. Slots 0..3 are not counted.
- R4: `flag_v`, `flag_u` and `flag_c` carry slots 28, 29 and 30 unchanged. `flag_v`=1 marks a sample that is not valid for playback.
- R5: `slot_kind` encodes 0 as channel A, 1 as channel B, 2 as channel A that starts a block, and 3 as reserved. `smp_chan` is 0 for kinds 0 and 2, and 1 for kind 1.
- R6: `smp_valid` is high for exactly one cycle: the cycle after the clock edge that takes slot 31. All other outputs hold their values until the next strobe.
- R7: `frame_idx` is 0 for a block-start subframe. Otherwise it is the current count. The count advances after each completed channel B subframe and wraps from 191 to 0.
- R8: `block_start` is 1 with a strobe exactly when the reported subframe was of kind 2.
- R9: `block_sync_err` is 1 with the strobe of a kind-2 subframe when a previous kind 2 has been seen since reset and the count is not 0. Before the first kind 2, no error is raised.
- R10: Cycles with `slot_en` low neither advance the slot position nor alter captured slots. A new `slot_sof` in the middle of a subframe abandons it and starts over at slot 0.
- R11: A subframe of kind 3 is dropped. It produces no strobe and leaves the frame count unchanged.
- R12: After reset, `smp_valid`, `smp_data` and `frame_idx` are 0, and the block-start lock is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 1 | One slot is offered this cycle |
| slot_bit | input | 1 | Value of the offered slot |
| slot_sof | input | 1 | Offered slot is slot 0 of a subframe |
| slot_kind | input | 2 | Subframe kind, sampled with `slot_sof` |
| smp_valid | output | 1 | One-cycle strobe for a completed subframe |
| smp_data | output | 24 | Audio sample, MSB-aligned |
| smp_chan | output | 1 | 0 = channel A, 1 = channel B |
| smp_aux | output | 4 | Auxiliary nibble |
| flag_v | output | 1 | Validity flag (1 = not valid) |
| flag_u | output | 1 | User bit |
| flag_c | output | 1 | Channel-status bit |
| parity_err | output | 1 | Odd parity over slots 4..31 |
| block_start | output | 1 | Subframe opened a status block |
| frame_idx | output | 8 | Frame position in the block, 0..191 |
| block_sync_err | output | 1 | Block start arrived at the wrong count |

## Verification
The bench runs one complete status block and places a block start exactly at the wrap, where a counter that is off by one would flag a false sync error. It then places a block start two frames later, where a correct design must flag it. It injects parity faults at random, inserts idle gaps between slots, and sends a reserved kind between an A and a B subframe. A design that counted a dropped subframe, or that strobed on it, would shift every later frame index. A truncated subframe followed by a fresh start checks for a design that ignores the restart: it would strobe at the wrong time or deliver a mix of the two subframes. A second instance with the nibble folded into the sample catches a swapped or misaligned field layout.

// File: rtl/asc_pkg.sv
// Shared slot positions and subframe kind codes for the subframe checker.
// Assumes the fixed 32-slot subframe layout; only the block length is tunable.
package asc_pkg;
    localparam int SF_SLOTS = 32;
    localparam int SLOT_W   = $clog2(SF_SLOTS);
    localparam int AUX_LO   = 4;
    localparam int AUX_W    = 4;
    localparam int AUD_LO   = 8;
    localparam int AUD_W    = 20;
    localparam int V_SLOT   = 28;
    localparam int U_SLOT   = 29;
    localparam int C_SLOT   = 30;
    localparam int P_SLOT   = 31;
    localparam int SMP_W    = AUD_W + AUX_W;

    typedef enum logic [1:0] {
        KIND_A   = 2'd0,
        KIND_B   = 2'd1,
        KIND_S   = 2'd2,
        KIND_RSV = 2'd3
    } sf_kind_e;
endpackage

// File: rtl/asc_slot_seq.sv
// Slot sequencer: tracks which slot of the subframe is being offered.
// Assumes slot_kind is meaningful only together with slot_sof; a reserved
// kind leaves the sequencer idle until the next start of subframe.
module asc_slot_seq
    import asc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_en,
    input  logic                slot_sof,
    input  sf_kind_e            slot_kind,
    output logic                take,
    output logic [SLOT_W-1:0]   cur_slot,
    output logic                last,
    output sf_kind_e            kind_q
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SF_SLOTS - 1);

    logic              active_q;
    logic [SLOT_W-1:0] slot_q;

    // Decode which slot this cycle carries and whether it is accepted.
    always_comb begin
        cur_slot = slot_sof ? '0 : slot_q;
        take     = slot_en && (slot_sof ? (slot_kind != KIND_RSV) : active_q);
        last     = take && (cur_slot == LAST_SLOT);
    end

    // Advance the slot position and latch the kind at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            kind_q   <= KIND_A;
        end else if (slot_en) begin
            if (slot_sof) begin
                active_q <= (slot_kind != KIND_RSV);
                slot_q   <= SLOT_W'(1);
                if (slot_kind != KIND_RSV) kind_q <= slot_kind;
            end else if (active_q) begin
                slot_q <= slot_q + SLOT_W'(1);
                if (slot_q == LAST_SLOT) active_q <= 1'b0;
            end
        end
    end

    // Kind stays fixed while a subframe is being received (R5).
    p_kind_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !slot_sof) |=> $stable(kind_q));

    // A mid-subframe slot moves the position by exactly one (R10).
    p_slot_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !slot_sof && !last) |=> (slot_q == $past(slot_q) + SLOT_W'(1)));
endmodule

// File: rtl/asc_capture.sv
// Slot capture and field decode: stores slots 0..30 by position and, on the
// cycle of slot 31, presents the decoded fields and the parity result.
// Assumes the outputs are only consumed while 'last' is high.
module asc_capture
    import asc_pkg::*;
#(
    parameter bit AUX_AS_AUDIO = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [SLOT_W-1:0]   cur_slot,
    input  logic                slot_bit,
    output logic [SMP_W-1:0]    sample,
    output logic [AUX_W-1:0]    aux,
    output logic                fv,
    output logic                fu,
    output logic                fc,
    output logic                par_err
);
    logic [SF_SLOTS-2:0] hold_q;
    logic [SF_SLOTS-1:0] full;

    // Store each accepted slot at its own position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            for (int i = 0; i < SF_SLOTS - 1; i++) begin
                if (take && cur_slot == SLOT_W'(i)) hold_q[i] <= slot_bit;
            end
        end
    end

    // Join the stored slots with the slot arriving now.
    always_comb begin
        full    = {slot_bit, hold_q};
        aux     = full[AUX_LO +: AUX_W];
        fv      = full[V_SLOT];
        fu      = full[U_SLOT];
        fc      = full[C_SLOT];
        par_err = ^full[P_SLOT:AUX_LO];
    end

    generate
        if (AUX_AS_AUDIO) begin : g_wide
            // Auxiliary nibble forms the low bits of the sample.
            always_comb sample = full[AUD_LO + AUD_W - 1:AUX_LO];
        end else begin : g_narrow
            // Audio word MSB-aligned, low bits cleared.
            always_comb sample = {full[AUD_LO +: AUD_W], {AUX_W{1'b0}}};
        end
    endgenerate

    // Idle cycles leave the captured slots untouched (R10).
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(hold_q));
endmodule

// File: rtl/asc_block_track.sv
// Status-block tracker: counts frames within a block and checks that block
// starts arrive at the wrap point once the count has locked.
// Assumes 'done' pulses once per accepted subframe, with its kind.
module asc_block_track
    import asc_pkg::*;
#(
    parameter int FRAMES = 192,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  sf_kind_e          kind,
    output logic [IDX_W-1:0]  idx_now,
    output logic              sync_now,
    output logic              start_now
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

    logic [IDX_W-1:0] cnt_q;
    logic             locked_q;

    // Position and sync verdict for the subframe completing now.
    always_comb begin
        start_now = (kind == KIND_S);
        idx_now   = start_now ? '0 : cnt_q;
        sync_now  = start_now && locked_q && (cnt_q != '0);
    end

    // Resync on a block start, advance after each channel B subframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else if (done) begin
            if (kind == KIND_S) begin
                cnt_q    <= '0;
                locked_q <= 1'b1;
            end else if (kind == KIND_B) begin
                cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + IDX_W'(1);
            end
        end
    end

    // Count never leaves the block range (R7).
    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

    // Channel B at the last frame wraps the count to zero (R7).
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == KIND_B && cnt_q == LAST_IDX) |=> (cnt_q == '0));
endmodule

// File: rtl/audio_subframe_checker.sv
// Top level: ties the sequencer, capture and block tracker together and
// registers one result per completed subframe with a one-cycle strobe.
// Assumes slots arrive in order; a new start of subframe abandons any
// partial one.
module audio_subframe_checker
    import asc_pkg::*;
#(
    parameter bit AUX_AS_AUDIO = 1'b0,
    parameter int FRAMES       = 192,
    localparam int IDX_W       = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              slot_bit,
    input  logic              slot_sof,
    input  logic [1:0]        slot_kind,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data,
    output logic              smp_chan,
    output logic [AUX_W-1:0]  smp_aux,
    output logic              flag_v,
    output logic              flag_u,
    output logic              flag_c,
    output logic              parity_err,
    output logic              block_start,
    output logic [IDX_W-1:0]  frame_idx,
    output logic              block_sync_err
);
    logic              take;
    logic              last;
    logic [SLOT_W-1:0] cur_slot;
    sf_kind_e          kind_q;
    logic [SMP_W-1:0]  d_sample;
    logic [AUX_W-1:0]  d_aux;
    logic              d_v, d_u, d_c, d_par;
    logic [IDX_W-1:0]  d_idx;
    logic              d_sync, d_start;

    asc_slot_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_en  (slot_en),
        .slot_sof (slot_sof),
        .slot_kind(sf_kind_e'(slot_kind)),
        .take     (take),
        .cur_slot (cur_slot),
        .last     (last),
        .kind_q   (kind_q)
    );

    asc_capture #(.AUX_AS_AUDIO(AUX_AS_AUDIO)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .cur_slot(cur_slot),
        .slot_bit(slot_bit),
        .sample  (d_sample),
        .aux     (d_aux),
        .fv      (d_v),
        .fu      (d_u),
        .fc      (d_c),
        .par_err (d_par)
    );

    asc_block_track #(.FRAMES(FRAMES)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (last),
        .kind     (kind_q),
        .idx_now  (d_idx),
        .sync_now (d_sync),
        .start_now(d_start)
    );

    // Register the decoded subframe and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid      <= 1'b0;
            smp_data       <= '0;
            smp_chan       <= 1'b0;
            smp_aux        <= '0;
            flag_v         <= 1'b0;
            flag_u         <= 1'b0;
            flag_c         <= 1'b0;
            parity_err     <= 1'b0;
            block_start    <= 1'b0;
            frame_idx      <= '0;
            block_sync_err <= 1'b0;
        end else begin
            smp_valid <= last;
            if (last) begin
                smp_data       <= d_sample;
                smp_chan       <= (kind_q == KIND_B);
                smp_aux        <= d_aux;
                flag_v         <= d_v;
                flag_u         <= d_u;
                flag_c         <= d_c;
                parity_err     <= d_par;
                block_start    <= d_start;
                frame_idx      <= d_idx;
                block_sync_err <= d_sync;
            end
        end
    end

    // Strobe never lasts two cycles (R6).
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // Outputs hold between strobes (R6).
    p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> ($stable(smp_data) && $stable(frame_idx) && $stable(parity_err)));

    // A block start is always frame 0 on channel A (R8).
    p_blkstart_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && block_start) |-> (frame_idx == '0 && !smp_chan));

    // Sync errors only accompany block starts (R9).
    p_sync_only_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && block_sync_err) |-> block_start);
endmodule

// File: tb/test_audio_subframe_checker.sv
// Bench for the subframe checker: random payloads with directed block,
// parity, reserved-kind and restart cases, checked against a bench model.
module test_audio_subframe_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_en = 1'b0, slot_bit = 1'b0, slot_sof = 1'b0;
    logic [1:0]  slot_kind = 2'd0;
    logic        smp_valid, smp_chan, flag_v, flag_u, flag_c;
    logic        parity_err, block_start, block_sync_err;
    logic [23:0] smp_data;
    logic [3:0]  smp_aux;
    logic [7:0]  frame_idx;
    logic        w_valid, w_chan, w_v, w_u, w_c, w_par, w_bs, w_se;
    logic [23:0] w_data;
    logic [3:0]  w_aux;
    logic [7:0]  w_idx;

    int n_tests = 0, n_fail = 0;
    int m_cnt = 0;
    bit m_locked = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_subframe_checker i_audio_subframe_checker (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_bit(slot_bit),
        .slot_sof(slot_sof), .slot_kind(slot_kind), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_chan(smp_chan), .smp_aux(smp_aux),
        .flag_v(flag_v), .flag_u(flag_u), .flag_c(flag_c),
        .parity_err(parity_err), .block_start(block_start),
        .frame_idx(frame_idx), .block_sync_err(block_sync_err)
    );

    audio_subframe_checker #(.AUX_AS_AUDIO(1'b1)) i_wide (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_bit(slot_bit),
        .slot_sof(slot_sof), .slot_kind(slot_kind), .smp_valid(w_valid),
        .smp_data(w_data), .smp_chan(w_chan), .smp_aux(w_aux),
        .flag_v(w_v), .flag_u(w_u), .flag_c(w_c), .parity_err(w_par),
        .block_start(w_bs), .frame_idx(w_idx), .block_sync_err(w_se)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] build_word(input logic [3:0] aux, input logic [19:0] aud,
                                               input logic v, u, c, bad);
        logic [31:0] w;
        w        = 32'($urandom);
        w[7:4]   = aux;
        w[27:8]  = aud;
        w[28]    = v;
        w[29]    = u;
        w[30]    = c;
        w[31]    = ^{aux, aud, v, u, c} ^ bad;
        return w;
    endfunction

    // Drive slots first..last of a word, with random idle gaps (R10).
    task automatic drive_slots(input logic [31:0] w, input logic [1:0] kind, input int n,
                               output bit stray);
        stray = 1'b0;
        for (int s = 0; s < n; s++) begin
            if (s > 0 && ($urandom % 4) == 0) begin
                @(negedge clk);
                if (smp_valid) stray = 1'b1;
                slot_en  = 1'b0;
                slot_sof = 1'b0;
                slot_bit = 1'($urandom);
            end
            @(negedge clk);
            if (smp_valid) stray = 1'b1;
            slot_en   = 1'b1;
            slot_bit  = w[s];
            slot_sof  = (s == 0);
            slot_kind = (s == 0) ? kind : 2'($urandom);
        end
    endtask

    task automatic send_sf(input logic [1:0] kind, input logic bad);
        logic [3:0]  aux = 4'($urandom);
        logic [19:0] aud = 20'($urandom);
        logic v = 1'($urandom), u = 1'($urandom), c = 1'($urandom);
        logic [31:0] w = build_word(aux, aud, v, u, c, bad);
        int e_idx;
        bit e_sync, stray;
        e_idx  = (kind == 2'd2) ? 0 : m_cnt;
        e_sync = (kind == 2'd2) && m_locked && (m_cnt != 0);
        drive_slots(w, kind, 32, stray);
        @(negedge clk);
        slot_en  = 1'b0;
        slot_sof = 1'b0;
        chk("R6 no stray strobe", 32'(stray), 0);
        if (kind == 2'd3) begin
            chk("R11 reserved kind strobe", 32'(smp_valid), 0);
        end else begin
            chk("R6 strobe after slot 31", 32'(smp_valid), 1);
            chk("R1 aux field", 32'(smp_aux), 32'(aux));
            chk("R2 sample narrow layout", 32'(smp_data), 32'({aud, 4'b0}));
            chk("R2 sample wide layout", 32'(w_data), 32'({aud, aux}));
            chk("R3 parity", 32'(parity_err), 32'(bad));
            chk("R4 flags vuc", 32'({flag_v, flag_u, flag_c}), 32'({v, u, c}));
            chk("R5 channel tag", 32'(smp_chan), 32'(kind == 2'd1));
            chk("R7 frame index", 32'(frame_idx), 32'(e_idx));
            chk("R8 block start", 32'(block_start), 32'(kind == 2'd2));
            chk("R9 sync error", 32'(block_sync_err), 32'(e_sync));
            if (kind == 2'd2) begin
                m_cnt    = 0;
                m_locked = 1'b1;
            end else if (kind == 2'd1) begin
                m_cnt = (m_cnt == 191) ? 0 : m_cnt + 1;
            end
        end
        @(negedge clk);
        chk("R6 single cycle strobe", 32'(smp_valid), 0);
    endtask

    initial begin
        bit stray;
        void'($urandom(32'd7031));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset valid", 32'(smp_valid), 0);
        chk("R12 reset data", 32'(smp_data), 0);
        chk("R12 reset index", 32'(frame_idx), 0);

        // Unlocked start: first block start raises no error (R9, R12).
        send_sf(2'd0, 1'b0);
        send_sf(2'd1, 1'b0);
        send_sf(2'd2, 1'b1);
        send_sf(2'd1, 1'b0);
        // One full block, block start exactly at wrap (R7, R9).
        for (int f = 1; f < 192; f++) begin
            send_sf(2'd0, 1'(($urandom % 8) == 0));
            send_sf(2'd1, 1'(($urandom % 8) == 0));
        end
        send_sf(2'd2, 1'b0);
        send_sf(2'd1, 1'b0);
        // Early block start after lock must be flagged (R9).
        send_sf(2'd0, 1'b0);
        send_sf(2'd1, 1'b1);
        send_sf(2'd2, 1'b0);
        send_sf(2'd1, 1'b0);
        // Reserved kind between A and B is dropped (R11).
        send_sf(2'd0, 1'b0);
        send_sf(2'd3, 1'b0);
        send_sf(2'd1, 1'b0);
        // Truncated subframe, then a fresh start (R10).
        drive_slots(32'($urandom), 2'd1, 17, stray);
        send_sf(2'd0, 1'b1);
        send_sf(2'd1, 1'b0);
        drive_slots(32'($urandom), 2'd0, 30, stray);
        send_sf(2'd1, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule